// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two words of `WIDTH` bits plus a carry input. The word is split into 4-bit adder slices. Each slice reports an active-LOW group propagate and an active-LOW group generate. A four-group lookahead unit returns every slice's carry input, so no carry ripples from slice to slice. Each lookahead unit covers up to four slices, which is 16 bits. For wider words, the carry out of one 16-bit lookahead block ripples into the next. A width that leaves the last block short, such as 28 bits, ties the missing slot so that it does not change the result.

A parameter selects the operand polarity. In the active-HIGH mode an operand bit means one when it is 1. In the active-LOW mode an operand bit means one when it is 0, and the sum is driven inverted. The carries are active-HIGH in both modes, and the slices connect to the lookahead unit the same way in both.

The sum and the final carry-out are registered once. A synchronous active-high reset clears them.

Top module: `cla_adder`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `sum` and `cout` become 0 after that edge.
- R2: In the active-HIGH mode, `{cout, sum}` equals `a + b + cin` of the inputs sampled at the previous rising edge (one cycle of latency).
- R3: In the active-LOW mode, let T = (~a) + (~b) + cin computed over WIDTH+1 bits. Then `sum` equals the bitwise inverse of T's low WIDTH bits, and `cout` equals T's top bit. `cin` and `cout` stay active-HIGH in this mode.
- R4: A slice whose operand nibble asserts its group generate (for example 8 + 8) sets the carry into the next slice, so the result carries across the 4-bit boundary.
- R5: When every slice propagates and none generates (a all ones, b zero, cin 1), the carry input travels through all slices and lookahead blocks. The result is `sum` = 0 and `cout` = 1.
- R6: A slice that neither propagates nor generates (both nibbles 0) blocks the carry input, so only the lowest bit position gains it.
- R7: The carry out of one 16-bit lookahead block enters the next block (for example 0x0000FFFF + 1 = 0x00010000).
- R8: With a width that is not a multiple of 16 (28 bits), the unused slot of the last lookahead unit has no effect. 0x0FFFFFFF + 1 gives `sum` = 0 and `cout` = 1.
- R9: An 8-bit configuration gives the correct `{cout, sum}` for every pair of 8-bit operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | WIDTH | First operand, in the polarity set by `POL` |
| b | input | WIDTH | Second operand, in the polarity set by `POL` |
| cin | input | 1 | Carry input, active high |
| sum | output | WIDTH | Registered sum, in the polarity set by `POL` |
| cout | output | 1 | Registered carry-out of the whole word, active high |

## Verification
The hardest condition to reach is a carry that enters at bit 0 and must survive every slice, every lookahead unit, every ripple between blocks and the tied slot of a short last block. Random operands almost never produce it. Directed operands build it on purpose: all-ones against zero, a run of ones that ends exactly on a 16-bit boundary, and an all-ones 28-bit word. The same operands drive an active-LOW 64-bit instance, where the all-ones pattern means zero in true terms, so that instance exercises the opposite corner. An exhaustive 8-bit sweep covers every generate, propagate and kill mix inside one lookahead unit.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Operand sense of the adder slices.
  typedef enum logic {OPS_HIGH = 1'b0, OPS_LOW = 1'b1} ops_pol_e;

  localparam int SLICE_W = 4;  // bits per adder slice
  localparam int GROUPS  = 4;  // slices served by one lookahead unit
  localparam int BLOCK_W = SLICE_W * GROUPS;
endpackage

// File: rtl/cla4_unit.sv
// Four-group lookahead: active-LOW group propagate/generate in,
// active-HIGH carries out, active-LOW block propagate/generate out.
module cla4_unit (
  input  logic [3:0] p_n,
  input  logic [3:0] g_n,
  input  logic       cin,
  output logic       cx,
  output logic       cy,
  output logic       cz,
  output logic       gp_n,
  output logic       gg_n
);
  logic [3:0] p, g;

  assign p = ~p_n;
  assign g = ~g_n;

  assign cx = g[0] | (p[0] & cin);
  assign cy = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
  assign cz = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
            | (p[2] & p[1] & p[0] & cin);

  assign gg_n = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                | (p[3] & p[2] & p[1] & g[0]));
  assign gp_n = ~(&p);
endmodule

// File: rtl/add4_slice.sv
// 4-bit adder slice exporting active-LOW group propagate/generate.
module add4_slice
  import cla_pkg::*;
#(
  parameter ops_pol_e POL = OPS_HIGH
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               p_n,
  output logic               g_n
);
  logic [SLICE_W-1:0] at, bt, st, gb, pb, c;
  logic               gacc;

  // Operand sense only changes the bit meaning, never the carry wiring.
  generate
    if (POL == OPS_LOW) begin : g_low
      assign at  = ~a;
      assign bt  = ~b;
      assign sum = ~st;
    end else begin : g_high
      assign at  = a;
      assign bt  = b;
      assign sum = st;
    end
  endgenerate

  assign gb = at & bt;
  assign pb = at | bt;

  always_comb begin
    c[0] = cin;
    for (int i = 1; i < SLICE_W; i++)
      c[i] = gb[i-1] | (pb[i-1] & c[i-1]);
    st = at ^ bt ^ c;
  end

  always_comb begin
    gacc = 1'b0;
    for (int i = 0; i < SLICE_W; i++)
      gacc = gb[i] | (pb[i] & gacc);
  end

  assign g_n = ~gacc;
  assign p_n = ~(&pb);
endmodule

// File: rtl/cla_block.sv
// One lookahead unit with up to four slices; empty slots are tied so
// that they pass the carry unchanged.
module cla_block
  import cla_pkg::*;
#(
  parameter int       USED = GROUPS,
  parameter ops_pol_e POL  = OPS_HIGH
) (
  input  logic [USED*SLICE_W-1:0] a,
  input  logic [USED*SLICE_W-1:0] b,
  input  logic                    cin,
  output logic [USED*SLICE_W-1:0] sum,
  output logic                    cout,
  output logic [GROUPS-1:0]       slot_cin,
  output logic [GROUPS-1:0]       slot_p_n,
  output logic [GROUPS-1:0]       slot_g_n
);
  logic cx, cy, cz, gp_n, gg_n;

  generate
    for (genvar i = 0; i < GROUPS; i++) begin : g_slot
      if (i < USED) begin : g_slice
        add4_slice #(.POL(POL)) u_slice (
          .a   (a[i*SLICE_W +: SLICE_W]),
          .b   (b[i*SLICE_W +: SLICE_W]),
          .cin (slot_cin[i]),
          .sum (sum[i*SLICE_W +: SLICE_W]),
          .p_n (slot_p_n[i]),
          .g_n (slot_g_n[i])
        );
      end else begin : g_tie
        // propagate asserted, generate negated: a transparent slot
        assign slot_p_n[i] = 1'b0;
        assign slot_g_n[i] = 1'b1;
      end
    end
  endgenerate

  cla4_unit u_la (
    .p_n  (slot_p_n),
    .g_n  (slot_g_n),
    .cin  (cin),
    .cx   (cx),
    .cy   (cy),
    .cz   (cz),
    .gp_n (gp_n),
    .gg_n (gg_n)
  );

  assign slot_cin = {cz, cy, cx, cin};
  assign cout     = ~gg_n | (~gp_n & cin);
endmodule

// File: rtl/cla_adder.sv
// Hierarchical lookahead adder. WIDTH must be a multiple of SLICE_W.
module cla_adder
  import cla_pkg::*;
#(
  parameter int       WIDTH = 32,
  parameter ops_pol_e POL   = OPS_HIGH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NS = WIDTH / SLICE_W;
  localparam int NB = (NS + GROUPS - 1) / GROUPS;

  logic [NB:0]          blk_c;
  logic [NB*GROUPS-1:0] s_cin, s_p_n, s_g_n;
  logic [WIDTH-1:0]     sum_c;

  assign blk_c[0] = cin;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_blk
      localparam int LEFT = NS - k*GROUPS;
      localparam int USED = (LEFT >= GROUPS) ? GROUPS : LEFT;
      localparam int LO   = k*BLOCK_W;
      cla_block #(.USED(USED), .POL(POL)) u_blk (
        .a        (a[LO +: USED*SLICE_W]),
        .b        (b[LO +: USED*SLICE_W]),
        .cin      (blk_c[k]),
        .sum      (sum_c[LO +: USED*SLICE_W]),
        .cout     (blk_c[k+1]),
        .slot_cin (s_cin[k*GROUPS +: GROUPS]),
        .slot_p_n (s_p_n[k*GROUPS +: GROUPS]),
        .slot_g_n (s_g_n[k*GROUPS +: GROUPS])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= blk_c[NB];
    end
  end
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk
  import cla_pkg::*;
#(
  parameter int       WIDTH = 32,
  parameter ops_pol_e POL   = OPS_HIGH,
  parameter int       NB    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [WIDTH-1:0]     a,
  input logic [WIDTH-1:0]     b,
  input logic                 cin,
  input logic [WIDTH-1:0]     sum,
  input logic                 cout,
  input logic [NB*GROUPS-1:0] s_cin,
  input logic [NB*GROUPS-1:0] s_p_n,
  input logic [NB*GROUPS-1:0] s_g_n,
  input logic [NB:0]          blk_c
);
  localparam int NSL = NB*GROUPS;

  logic [WIDTH-1:0] at, bt, sum_t;
  logic [WIDTH:0]   exp_t;
  logic [NSL-1:0]   nxt;

  assign at    = (POL == OPS_LOW) ? ~a : a;
  assign bt    = (POL == OPS_LOW) ? ~b : b;
  assign sum_t = (POL == OPS_LOW) ? ~sum : sum;
  assign exp_t = {1'b0, at} + {1'b0, bt} + {{WIDTH{1'b0}}, cin};

  // R1: reset clears the registered outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && cout == 1'b0));

  // R2 (active-HIGH) / R3 (active-LOW): one-cycle true-sense addition
  a_r2_r3_sum: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum_t} == $past(exp_t)));

  a_r7_first_carry: assert property (@(posedge clk) disable iff (rst)
    s_cin[0] == cin);

  generate
    for (genvar j = 0; j < NSL; j++) begin : g_slot
      if (j % GROUPS == GROUPS-1) begin : g_end
        assign nxt[j] = blk_c[j/GROUPS + 1];
      end else begin : g_mid
        assign nxt[j] = s_cin[j+1];
      end

      a_r4_gen_sets_carry: assert property (@(posedge clk) disable iff (rst)
        !s_g_n[j] |-> nxt[j]);

      a_r6_kill_clears: assert property (@(posedge clk) disable iff (rst)
        (s_g_n[j] && s_p_n[j]) |-> !nxt[j]);

      a_r5_prop_passes: assert property (@(posedge clk) disable iff (rst)
        (s_g_n[j] && !s_p_n[j]) |-> (nxt[j] == s_cin[j]));
    end
  endgenerate
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .POL(POL), .NB(NB)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .s_cin (s_cin),
  .s_p_n (s_p_n),
  .s_g_n (s_g_n),
  .blk_c (blk_c)
);

// File: tb/cla_adder_test.sv
module cla_adder_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a64 = '0;
  logic [63:0] b64 = '0;
  logic        cin = 1'b0;

  logic [31:0] s32;  logic c32;
  logic [27:0] s28;  logic c28;
  logic [7:0]  s8;   logic c8;
  logic [63:0] s64;  logic c64;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    string       tag;
    logic [32:0] e32;
    logic [28:0] e28;
    logic [8:0]  e8;
    logic [64:0] e64;
  } item_t;

  item_t sb[$];
  item_t mon_it;

  always #(CLK_P/2) clk = ~clk;

  cla_adder #(.WIDTH(32)) uut (
    .clk(clk), .rst(rst), .a(a64[31:0]), .b(b64[31:0]), .cin(cin),
    .sum(s32), .cout(c32));
  cla_adder #(.WIDTH(28)) u28 (
    .clk(clk), .rst(rst), .a(a64[27:0]), .b(b64[27:0]), .cin(cin),
    .sum(s28), .cout(c28));
  cla_adder #(.WIDTH(8)) u8 (
    .clk(clk), .rst(rst), .a(a64[7:0]), .b(b64[7:0]), .cin(cin),
    .sum(s8), .cout(c8));
  cla_adder #(.WIDTH(64), .POL(cla_pkg::OPS_LOW)) u64n (
    .clk(clk), .rst(rst), .a(a64), .b(b64), .cin(cin),
    .sum(s64), .cout(c64));

  task automatic chk(input bit ok, input string req, input string tag,
                     input logic [64:0] act, input logic [64:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  // Driver: apply one operand set and queue the expected results.
  task automatic drive(input logic [63:0] av, input logic [63:0] bv,
                       input logic cv, input string tag);
    item_t       it;
    logic [64:0] t;
    @(negedge clk);
    a64 = av; b64 = bv; cin = cv;
    it.tag = tag;
    it.e32 = {1'b0, av[31:0]} + {1'b0, bv[31:0]} + 33'(cv);
    it.e28 = {1'b0, av[27:0]} + {1'b0, bv[27:0]} + 29'(cv);
    it.e8  = {1'b0, av[7:0]}  + {1'b0, bv[7:0]}  + 9'(cv);
    t      = {1'b0, ~av} + {1'b0, ~bv} + 65'(cv);
    it.e64 = {t[64], ~t[63:0]};
    sb.push_back(it);
  endtask

  // Monitor: results appear after the edge that follows the drive.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (sb.size() != 0) begin
      mon_it = sb.pop_front();
      chk({c32, s32} === mon_it.e32, "R2 w32", mon_it.tag,
          65'({c32, s32}), 65'(mon_it.e32));
      chk({c28, s28} === mon_it.e28, "R8 w28", mon_it.tag,
          65'({c28, s28}), 65'(mon_it.e28));
      chk({c8, s8} === mon_it.e8, "R9 w8", mon_it.tag,
          65'({c8, s8}), 65'(mon_it.e8));
      chk({c64, s64} === mon_it.e64, "R3 w64 low", mon_it.tag,
          {c64, s64}, mon_it.e64);
    end
  end

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    a64 = 64'hDEAD_BEEF_1234_5678;
    b64 = 64'h0F0F_F0F0_AAAA_5555;
    cin = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held clear while reset is high
    chk({c32, s32} === 33'd0, "R1 w32", "reset", 65'({c32, s32}), 65'd0);
    chk({c28, s28} === 29'd0, "R1 w28", "reset", 65'({c28, s28}), 65'd0);
    chk({c8, s8}   === 9'd0,  "R1 w8",  "reset", 65'({c8, s8}),   65'd0);
    chk({c64, s64} === 65'd0, "R1 w64", "reset", {c64, s64},      65'd0);
    rst = 1'b0;

    drive(64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008, 1'b0, "R4 generate");
    drive(64'h0000_0000_0000_0880, 64'h0000_0000_0000_0880, 1'b1, "R4 generate");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R5 full propagate");
    drive(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 full propagate");
    drive(64'hF0F0_F0F0_F0F0_F0F0, 64'h0, 1'b1, "R6 kill");
    drive(64'h0F0F_0F0F_0F0F_0F0F, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, "R6 kill");
    drive(64'h0000_FFFF_0000_FFFF, 64'h1, 1'b0, "R7 block ripple");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, "R7 block ripple");
    drive(64'h0000_0000_0FFF_FFFF, 64'h1, 1'b0, "R8 short block");
    drive(64'h0000_0000_0FFF_FFFF, 64'h0, 1'b1, "R8 short block");

    for (int i = 0; i < 2000; i++)
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R2 random");

    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib++)
        drive({$urandom, $urandom, 8'(ia)} , {$urandom, $urandom, 8'(ib)},
              1'(ia ^ (ib >> 1)), "R9 exhaustive");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule